// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block drives a multi-channel successive-approximation converter through sequences of conversions. A single control write sets the first channel and chooses between one channel and a rising sweep. It also picks one-shot or back-to-back sequencing, left or right alignment, and unsigned or two's-complement coding. The sequence length is sampled with that same write. Every conversion opens with a one-cycle start pulse to the converter, which marks the beginning of sampling, and ends when the converter returns a done pulse with a 10-bit code.

Each returned code is placed in a 16-bit slot and written into a bank of result registers. Result number i of a sequence goes to register i. A read index selects one register for software or a neighbouring block.

When the trigger enable input is high, a control write only arms the block, and each trigger pulse then runs one sequence. A control write at any time abandons the running sequence and begins again with the new settings.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A control write, whatever the state, abandons any running sequence. With trigger enable low, `cnv_start` is high in the cycle after the write, with `cnv_chan` equal to the written channel.
- R2: With trigger enable high, no conversion starts until a control write has been made since reset. The write itself starts nothing. After it, each `trig` pulse seen while idle starts one sequence. Pulses that arrive while a sequence runs, or while trigger enable is low, start nothing.
- R3: With trigger enable high, the continuous bit has no effect: each trigger runs exactly one sequence.
- R4: With trigger enable low, continuous bit 0 gives one sequence. Continuous bit 1 repeats the sequence back to back until the next control write.
- R5: In single-channel mode (`ctl_mult`=0), every conversion of the sequence uses the written 4-bit channel.
- R6: In multi-channel mode (`ctl_mult`=1), conversion i uses the written channel plus i, and it wraps from channel 15 to channel 0.
- R7: `ctl_len` gives the number of conversions per sequence, 1 to 15, and the value 0 means 16.
- R8: `cnv_start` lasts one cycle per conversion. The next start follows only the `cnv_done` of the current conversion. `cnv_chan` is held while a conversion is outstanding.
- R9: Left alignment (`ctl_rjust`=0, `ctl_signed`=0) puts the 10-bit code in bits 15:6 of the slot, with bits 5:0 zero.
- R10: Left alignment with `ctl_signed`=1 gives two's complement: the code's top bit is inverted in bit 15, and the rest is as in R9.
- R11: Right alignment (`ctl_rjust`=1) puts the code in bits 9:0, with bits 15:10 zero, and `ctl_signed` is then ignored.
- R12: The result of conversion i (counting from 0) of a sequence is stored in result register i. `rd_data` shows register `rd_idx`.
- R13: `seq_done` rises after the last result of a sequence is stored. It falls on a control write or when the next sequence issues its first start.
- R14: After reset the block is idle: `busy`, `seq_done` and `cnv_start` are 0, and all result registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Control write strobe, one cycle |
| ctl_chan | input | 4 | First channel of the sequence |
| ctl_mult | input | 1 | 1: sweep channels upward, 0: stay on one channel |
| ctl_scan | input | 1 | 1: repeat sequences (ignored when triggered) |
| ctl_rjust | input | 1 | 1: right aligned result, 0: left aligned |
| ctl_signed | input | 1 | 1: two's-complement coding (left alignment only) |
| ctl_len | input | 4 | Conversions per sequence, 0 means 16 |
| trig_en | input | 1 | External trigger mode |
| trig | input | 1 | Trigger event pulse |
| cnv_start | output | 1 | Start of sampling for one conversion |
| cnv_chan | output | 4 | Channel for the current conversion |
| cnv_done | input | 1 | Converter result valid, one cycle |
| cnv_data | input | 10 | Converter result code |
| rd_idx | input | 4 | Result register select |
| rd_data | output | 16 | Selected result register |
| busy | output | 1 | A sequence is running |
| seq_done | output | 1 | Sequence complete flag |

## Verification
Every cycle, the assertions check the following:
- the start pulse is a single cycle long;
- the channel stays put while a conversion is outstanding;
- a control write restarts at once on the written channel, or leaves the block idle in trigger mode;
- a write always clears the completion flag.

Some behaviour only the bench scenarios can show:
- the channel order, including the wrap past 15;
- the length decoding, including 0 as sixteen;
- the three slot formats and the register each result lands in;
- an abort that discards an outstanding conversion;
- the repeat loop of continuous mode, and its suppression under triggering.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
    localparam int CH_W   = 4;
    localparam int RAW_W  = 10;
    localparam int SLOT_W = 16;
    localparam int LEN_W  = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_BUSY  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [CH_W-1:0]  chan0;
        logic             mult;
        logic             scan;
        logic             rjust;
        logic             sgn;
        logic [LEN_W-1:0] len;
    } seq_cfg_t;

    typedef struct packed {
        seq_state_e       state;
        seq_cfg_t         cfg;
        logic [CH_W-1:0]  chan;
        logic [LEN_W-1:0] idx;
        logic             armed;
        logic             done;
    } seq_regs_t;
endpackage

// File: rtl/adc_res_fmt.sv
`timescale 1ns/1ps
module adc_res_fmt #(
    parameter int RAW_W  = 10,
    parameter int SLOT_W = 16,
    localparam int PAD_W = SLOT_W - RAW_W
) (
    input  logic [RAW_W-1:0]  raw,
    input  logic              rjust,
    input  logic              sgn,
    output logic [SLOT_W-1:0] slot
);
    logic [RAW_W-1:0] coded;

    always_comb begin
        coded = raw ^ {sgn, {(RAW_W-1){1'b0}}};
        if (rjust) slot = {{PAD_W{1'b0}}, raw};
        else       slot = {coded, {PAD_W{1'b0}}};
    end
endmodule

// File: rtl/adc_chan_next.sv
`timescale 1ns/1ps
module adc_chan_next #(
    parameter int CH_W = 4,
    parameter int NCH  = 16,
    localparam logic [CH_W-1:0] LAST = CH_W'(NCH - 1)
) (
    input  logic [CH_W-1:0] cur,
    input  logic            mult,
    output logic [CH_W-1:0] nxt
);
    always_comb begin
        if (!mult)            nxt = cur;
        else if (cur == LAST) nxt = '0;
        else                  nxt = cur + 1'b1;
    end
endmodule

// File: rtl/adc_res_bank.sv
`timescale 1ns/1ps
module adc_res_bank #(
    parameter int SLOT_W = 16,
    parameter int IDX_W  = 4,
    localparam int NSLOT = 2 ** IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [SLOT_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [SLOT_W-1:0] rd_data
);
    logic [NSLOT-1:0][SLOT_W-1:0] slots;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic [SLOT_W-1:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (wr_en && wr_idx == IDX_W'(g)) val_d = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= '0;
            else        val_q <= val_d;
        end

        assign slots[g] = val_q;
    end

    assign rd_data = slots[rd_idx];
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NCH = 2 ** CH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CH_W-1:0]   ctl_chan,
    input  logic              ctl_mult,
    input  logic              ctl_scan,
    input  logic              ctl_rjust,
    input  logic              ctl_signed,
    input  logic [LEN_W-1:0]  ctl_len,
    input  logic              trig_en,
    input  logic              trig,
    output logic              cnv_start,
    output logic [CH_W-1:0]   cnv_chan,
    input  logic              cnv_done,
    input  logic [RAW_W-1:0]  cnv_data,
    input  logic [LEN_W-1:0]  rd_idx,
    output logic [SLOT_W-1:0] rd_data,
    output logic              busy,
    output logic              seq_done
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    seq_regs_t         r_d, r_q;
    logic              wr_en;
    logic [CH_W-1:0]   chan_nxt;
    logic [SLOT_W-1:0] slot_fmt;

    adc_chan_next #(.CH_W(CH_W), .NCH(NCH)) u_step (
        .cur  (r_q.chan),
        .mult (r_q.cfg.mult),
        .nxt  (chan_nxt)
    );

    adc_res_fmt #(.RAW_W(RAW_W), .SLOT_W(SLOT_W)) u_fmt (
        .raw   (cnv_data),
        .rjust (r_q.cfg.rjust),
        .sgn   (r_q.cfg.sgn),
        .slot  (slot_fmt)
    );

    adc_res_bank #(.SLOT_W(SLOT_W), .IDX_W(LEN_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (r_q.idx),
        .wr_data (slot_fmt),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    always_comb begin
        r_d   = r_q;
        wr_en = 1'b0;
        if (ctl_wr) begin
            r_d.cfg.chan0 = ctl_chan;
            r_d.cfg.mult  = ctl_mult;
            r_d.cfg.scan  = ctl_scan;
            r_d.cfg.rjust = ctl_rjust;
            r_d.cfg.sgn   = ctl_signed;
            r_d.cfg.len   = ctl_len;
            r_d.chan      = ctl_chan;
            r_d.idx       = '0;
            r_d.armed     = 1'b1;
            r_d.done      = 1'b0;
            r_d.state     = trig_en ? ST_IDLE : ST_ISSUE;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (trig_en && r_q.armed && trig) begin
                        r_d.idx   = '0;
                        r_d.chan  = r_q.cfg.chan0;
                        r_d.state = ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    r_d.state = ST_BUSY;
                    if (r_q.idx == '0) r_d.done = 1'b0;
                end
                ST_BUSY: begin
                    if (cnv_done) begin
                        wr_en = 1'b1;
                        if (r_q.idx == r_q.cfg.len - ONE) begin
                            r_d.done  = 1'b1;
                            r_d.idx   = '0;
                            r_d.chan  = r_q.cfg.chan0;
                            r_d.state = (!trig_en && r_q.cfg.scan) ? ST_ISSUE : ST_IDLE;
                        end else begin
                            r_d.idx   = r_q.idx + ONE;
                            r_d.chan  = chan_nxt;
                            r_d.state = ST_ISSUE;
                        end
                    end
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cnv_start = (r_q.state == ST_ISSUE);
    assign cnv_chan  = r_q.chan;
    assign busy      = (r_q.state != ST_IDLE);
    assign seq_done  = r_q.done;
endmodule

// File: rtl/adc_seq_chk.sv
`timescale 1ns/1ps
module adc_seq_chk #(
    parameter int CH_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ctl_wr,
    input logic [CH_W-1:0] ctl_chan,
    input logic            trig_en,
    input logic            cnv_start,
    input logic            cnv_done,
    input logic [CH_W-1:0] cnv_chan,
    input logic            busy,
    input logic            seq_done
);
    // R8
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start && !ctl_wr |=> !cnv_start);

    // R8
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !cnv_start && !cnv_done && !ctl_wr |=> $stable(cnv_chan));

    // R1
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && !trig_en |=> cnv_start && cnv_chan == $past(ctl_chan));

    // R2
    arm_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && trig_en |=> !busy);

    // R13
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> !seq_done);
endmodule

bind adc_seq_ctrl adc_seq_chk #(.CH_W(adc_seq_pkg::CH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_chan  (ctl_chan),
    .trig_en   (trig_en),
    .cnv_start (cnv_start),
    .cnv_done  (cnv_done),
    .cnv_chan  (cnv_chan),
    .busy      (busy),
    .seq_done  (seq_done)
);

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;
    localparam int LAT  = 2;
    localparam int NVEC = 6;
    // fields: chan[10:7] mult[6] rjust[5] signed[4] len[3:0]
    localparam logic [10:0] VEC [NVEC] = '{
        {4'd3,  1'b0, 1'b0, 1'b0, 4'd3},   // R5 R9
        {4'd14, 1'b1, 1'b0, 1'b1, 4'd4},   // R6 wrap, R10
        {4'd7,  1'b1, 1'b1, 1'b1, 4'd2},   // R11 signed ignored
        {4'd5,  1'b1, 1'b0, 1'b0, 4'd0},   // R7 zero means sixteen
        {4'd0,  1'b0, 1'b1, 1'b0, 4'd1},   // R11
        {4'd15, 1'b1, 1'b0, 1'b1, 4'd5}    // R6 wrap from top
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        ctl_wr = 0, ctl_mult = 0, ctl_scan = 0, ctl_rjust = 0, ctl_signed = 0;
    logic [3:0]  ctl_chan = 0, ctl_len = 0, rd_idx = 0;
    logic        trig_en = 0, trig = 0, cnv_done, cnv_start, busy, seq_done;
    logic [3:0]  cnv_chan;
    logic [9:0]  cnv_data;
    logic [15:0] rd_data;

    logic [3:0]  log_ch  [512];
    logic [9:0]  log_dat [512];
    int          nlog = 0, nchk = 0, nfail = 0, done_seen = 0;
    logic        finished = 0;

    always #4 clk = ~clk;

    adc_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_chan(ctl_chan),
        .ctl_mult(ctl_mult), .ctl_scan(ctl_scan), .ctl_rjust(ctl_rjust),
        .ctl_signed(ctl_signed), .ctl_len(ctl_len), .trig_en(trig_en),
        .trig(trig), .cnv_start(cnv_start), .cnv_chan(cnv_chan),
        .cnv_done(cnv_done), .cnv_data(cnv_data), .rd_idx(rd_idx),
        .rd_data(rd_data), .busy(busy), .seq_done(seq_done)
    );

    function automatic logic [9:0] conv_val(input logic [3:0] ch, input int n);
        return 10'((int'(ch) * 73 + n * 29 + 300) % 1024);
    endfunction

    function automatic logic [15:0] fmt(input logic [9:0] d, input logic rj, input logic sg);
        if (rj)      return {6'b0, d};
        else if (sg) return {~d[9], d[8:0], 6'b0};
        else         return {d, 6'b0};
    endfunction

    // abstract converter: restarts on every start pulse
    initial begin
        int wt;
        int cur;
        wt = 0; cur = 0;
        cnv_done = 1'b0; cnv_data = '0;
        forever begin
            @(negedge clk);
            cnv_done = 1'b0;
            if (seq_done) done_seen++;
            if (cnv_start) begin
                log_ch[nlog]  = cnv_chan;
                log_dat[nlog] = conv_val(cnv_chan, nlog);
                cur = nlog;
                nlog++;
                wt = LAT;
            end else if (wt > 0) begin
                wt--;
                if (wt == 0) begin
                    cnv_done = 1'b1;
                    cnv_data = log_dat[cur];
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic ctl_write(input logic [3:0] ch, input logic m, input logic sc,
                             input logic rj, input logic sg, input logic [3:0] ln);
        @(negedge clk);
        ctl_chan = ch; ctl_mult = m; ctl_scan = sc;
        ctl_rjust = rj; ctl_signed = sg; ctl_len = ln; ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
        #1;
    endtask

    task automatic pulse_trig();
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int k;
        settle(3);
        k = 0;
        while (!seq_done && k < 800) begin
            settle(1);
            k++;
        end
        chk(req, 32'(seq_done), 32'd1);
    endtask

    task automatic read_slot(input logic [3:0] i, output logic [15:0] v);
        @(negedge clk);
        rd_idx = i;
        #1;
        v = rd_data;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int base, len;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle(1);

        // R14 reset state
        chk("R14 busy", 32'(busy), 0);
        chk("R14 seq_done", 32'(seq_done), 0);
        chk("R14 cnv_start", 32'(cnv_start), 0);
        read_slot(4'd0, v);  chk("R14 slot0", 32'(v), 0);
        read_slot(4'd15, v); chk("R14 slot15", 32'(v), 0);

        // R2: trigger before any control write is ignored
        trig_en = 1'b1;
        pulse_trig();
        settle(10);
        chk("R2 no start unarmed", 32'(nlog), 0);
        chk("R2 idle unarmed", 32'(busy), 0);
        trig_en = 1'b0;

        // table walk
        for (int t = 0; t < NVEC; t++) begin
            base = nlog;
            ctl_write(VEC[t][10:7], VEC[t][6], 1'b0, VEC[t][5], VEC[t][4], VEC[t][3:0]);
            wait_done("R13 done after sequence");
            settle(12);
            len = (VEC[t][3:0] == 0) ? 16 : int'(VEC[t][3:0]);
            chk("R7 R4 conversion count", 32'(nlog - base), 32'(len));
            for (int i = 0; i < len; i++) begin
                chk(VEC[t][6] ? "R6 channel" : "R5 channel", 32'(log_ch[base + i]),
                    32'(VEC[t][6] ? 4'(int'(VEC[t][10:7]) + i) : VEC[t][10:7]));
                read_slot(4'(i), v);
                chk(VEC[t][5] ? "R11 R12 slot" : (VEC[t][4] ? "R10 R12 slot" : "R9 R12 slot"),
                    32'(v), 32'(fmt(log_dat[base + i], VEC[t][5], VEC[t][4])));
            end
        end

        // R1 R13: write after completion clears the flag and starts at once
        base = nlog;
        ctl_write(4'd2, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4);
        chk("R13 cleared by write", 32'(seq_done), 0);
        chk("R1 immediate start", 32'(cnv_start), 1);
        chk("R1 start channel", 32'(cnv_chan), 2);
        // abort while conversion on channel 2 is outstanding
        ctl_write(4'd9, 1'b0, 1'b0, 1'b1, 1'b1, 4'd1);
        wait_done("R1 aborted sequence completes");
        settle(12);
        chk("R1 starts after abort", 32'(nlog - base), 2);
        chk("R1 new channel", 32'(log_ch[nlog - 1]), 9);
        read_slot(4'd0, v);
        chk("R1 R11 slot0 after abort", 32'(v), 32'(fmt(log_dat[nlog - 1], 1'b1, 1'b1)));

        // R4 continuous sequences
        base = nlog;
        done_seen = 0;
        ctl_write(4'd6, 1'b1, 1'b1, 1'b0, 1'b0, 4'd2);
        while (nlog - base < 7) settle(1);
        for (int i = 0; i < 6; i++)
            chk("R4 repeat channel", 32'(log_ch[base + i]), 32'(6 + (i % 2)));
        chk("R13 flag pulses in continuous", 32'(done_seen >= 2), 1);
        base = nlog;
        ctl_write(4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1);
        wait_done("R4 single after write");
        settle(20);
        chk("R4 continuous stopped", 32'(nlog - base), 1);

        // R2 R3 triggered mode
        trig_en = 1'b1;
        base = nlog;
        ctl_write(4'd4, 1'b1, 1'b1, 1'b0, 1'b0, 4'd3);
        settle(15);
        chk("R2 armed but idle", 32'(nlog - base), 0);
        chk("R2 not busy", 32'(busy), 0);
        pulse_trig();
        wait_done("R2 triggered sequence");
        settle(20);
        chk("R3 one sequence per trigger", 32'(nlog - base), 3);
        for (int i = 0; i < 3; i++)
            chk("R3 channel", 32'(log_ch[base + i]), 32'(4 + i));
        base = nlog;
        pulse_trig();
        settle(2);
        pulse_trig();   // lands while busy: ignored
        wait_done("R2 second trigger");
        settle(20);
        chk("R2 trigger while busy ignored", 32'(nlog - base), 3);

        // R2 trigger ignored when trigger mode off
        trig_en = 1'b0;
        base = nlog;
        pulse_trig();
        settle(15);
        chk("R2 trigger with mode off", 32'(nlog - base), 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule